// File: doc/BRIEF.md
# Prescaled 16-bit event counter with write/clear/count arbitration

The block is a 16-bit up-counter whose count source is picked from three taps of a free-running prescaler (the system clock divided by 2, 4 or 8) or from an external clock pin. The block samples the selected source once per system clock. A low sample followed by a high sample is one count event. Synchronisers sample the external clock pin and a capture pin. A rising edge on the capture pin copies the running count into a capture register. A synchronous clear input, typically driven by a compare-match elsewhere, zeroes the count.

Software reaches the block through a small register bus. Every write is a two-state cycle: the request is taken in the first state and lands in the register at the end of the second. When a write, a clear and a count event meet in the same cycle, fixed priorities decide the result. Because edge detection compares successive samples of whatever source is selected, switching from a source that is low to one that is high adds one count, on purpose. An overflow flag with an interrupt enable signals the wrap from all-ones to zero. A standby input freezes the block. While it is high, a pending interrupt cannot be cleared.

Top module: `tmr_cnt16`

## Requirements
- R1: After reset the count, capture register, control register (select 0, interrupt enable 0) and both flags read zero, and irq is low.
- R2: The prescaler is a 3-bit counter that is zero at reset and advances every clock. Select value 0, 1 and 2 uses prescaler bit 0, 1 and 2, so a steady selection advances the count once per 2, 4 and 8 clocks.
- R3: With select value 3, every external-clock pulse that stays high for at least two clocks and low for at least two clocks advances the count exactly once.
- R4: A write is taken when bus_wr is high at a clock edge (first state). The register changes at the following edge (second state), not before. Addresses: 0 count (read/write), 1 capture (read only), 2 control, 3 status.
- R5: When clr_in is high at an edge, the count becomes zero, even if a count event falls on that edge.
- R6: A clear in the second state of a count write wins: the count becomes zero and the written value is lost. A clear in the first state does not stop the write.
- R7: A count write in its second state wins over a count event on the same edge. The written value appears exactly and that event is lost.
- R8: Changing the selection while the old source sample is low and the new source is high adds exactly one count.
- R9: Status bit 0 (overflow) sets on the edge where a count event takes the count from 0xFFFF to 0x0000. irq equals overflow AND control bit 2.
- R10: Writing 0 to a status bit clears that flag. Writing 1 leaves it unchanged. Status bit 1 is the capture flag.
- R11: A rising edge on cap_in, held for at least two clocks, copies the count into the capture register and sets status bit 1.
- R12: While stby is high, the count is frozen and all register writes and clears are ignored. A pending irq therefore stays asserted.
- R13: The control register reads back the select value in bits 1:0 and the overflow interrupt enable in bit 2. All other read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stby | input | 1 | Standby: freezes counting and register updates |
| bus_wr | input | 1 | Write request, sampled at the first state |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| ext_clk | input | 1 | External count source |
| cap_in | input | 1 | Capture trigger |
| clr_in | input | 1 | Synchronous counter clear |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is the switch-over count. Whether it happens depends on the prescaler phase at the moment the new selection lands, and that phase is not visible at the ports. The bench switches from an idle external pin to the divide-by-8 tap eight times in a row, with every iteration exactly 25 clocks long. The eight switches therefore meet all eight prescaler phases. The bench checks that each window counts two or three events, and that exactly three phases yield the extra count, for 19 events in total. The write-versus-count race is reached the same way, by repeating the write on two adjacent clock parities.

// File: rtl/tmr_cnt16.sv
module tmr_cnt16 #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stby,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          ext_clk,
  input  logic          cap_in,
  input  logic          clr_in,
  output logic          irq
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [2:0]    psc;
  logic [1:0]    sel;
  logic          ovf_ie, ovf_f, cap_f;
  logic [CW-1:0] cnt_q, cap_q;
  logic          wr_pend;
  logic [1:0]    addr_p;
  logic [CW-1:0] wdata_p;
  logic [1:0]    ext_sync, cap_sync;
  logic          cap_d, src_d, src_lvl;
  logic          inc, cap_edge;

  always_comb begin
    case (sel)
      2'd0:    src_lvl = psc[0];
      2'd1:    src_lvl = psc[1];
      2'd2:    src_lvl = psc[2];
      default: src_lvl = ext_sync[1];
    endcase
  end

  wire live   = ~stby;
  wire wr_cnt = wr_pend & (addr_p == 2'd0) & live;
  wire wr_ctl = wr_pend & (addr_p == 2'd2) & live;
  wire wr_sts = wr_pend & (addr_p == 2'd3) & live;
  assign inc      = src_lvl & ~src_d & live;
  assign cap_edge = cap_sync[1] & ~cap_d;
  wire ovf_evt = inc & ~clr_in & ~wr_cnt & (cnt_q == CMAX);
  wire cap_evt = cap_edge & live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc      <= '0;
      ext_sync <= '0;
      cap_sync <= '0;
      cap_d    <= 1'b0;
      src_d    <= 1'b0;
      wr_pend  <= 1'b0;
      addr_p   <= '0;
      wdata_p  <= '0;
    end else begin
      psc      <= psc + 3'd1;
      ext_sync <= {ext_sync[0], ext_clk};
      cap_sync <= {cap_sync[0], cap_in};
      cap_d    <= cap_sync[1];
      src_d    <= src_lvl;
      wr_pend  <= bus_wr;
      addr_p   <= bus_addr;
      wdata_p  <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cap_q  <= '0;
      sel    <= 2'd0;
      ovf_ie <= 1'b0;
      ovf_f  <= 1'b0;
      cap_f  <= 1'b0;
    end else if (live) begin
      if (clr_in)      cnt_q <= '0;
      else if (wr_cnt) cnt_q <= wdata_p;
      else if (inc)    cnt_q <= cnt_q + 1'b1;
      if (wr_ctl) {ovf_ie, sel} <= wdata_p[2:0];
      if (cap_evt) cap_q <= cnt_q;
      ovf_f <= (ovf_f & ~(wr_sts & ~wdata_p[0])) | ovf_evt;
      cap_f <= (cap_f & ~(wr_sts & ~wdata_p[1])) | cap_evt;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = cnt_q;
      2'd1:    bus_rdata = cap_q;
      2'd2:    bus_rdata = {{(CW-3){1'b0}}, ovf_ie, sel};
      default: bus_rdata = {{(CW-2){1'b0}}, cap_f, ovf_f};
    endcase
  end

  assign irq = ovf_f & ovf_ie;
endmodule

module tmr_cnt16_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stby,
  input logic          clr_in,
  input logic          wr_pend,
  input logic [1:0]    addr_p,
  input logic [CW-1:0] wdata_p,
  input logic [CW-1:0] cnt_q,
  input logic          inc,
  input logic          cap_edge,
  input logic          ovf_f,
  input logic          cap_f
);
  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && clr_in) |=> (cnt_q == '0));

  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && !clr_in && wr_pend && addr_p == 2'd0) |=> (cnt_q == $past(wdata_p)));

  p_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> $stable(cnt_q));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && !clr_in && !(wr_pend && addr_p == 2'd0))
      |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  p_wrap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr_in && !(wr_pend && addr_p == 2'd0) && cnt_q == '1)
      |=> (ovf_f && cnt_q == '0));

  p_capture_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && cap_edge) |=> cap_f);
endmodule

bind tmr_cnt16 tmr_cnt16_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stby(stby), .clr_in(clr_in),
  .wr_pend(wr_pend), .addr_p(addr_p), .wdata_p(wdata_p), .cnt_q(cnt_q),
  .inc(inc), .cap_edge(cap_edge), .ovf_f(ovf_f), .cap_f(cap_f)
);

// File: tb/tmr_cnt16_tb.sv
module tmr_cnt16_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stby = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_clk = 1'b0;
  logic        cap_in = 1'b0;
  logic        clr_in = 1'b0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tmr_cnt16 u_dut (
    .clk(clk), .rst_n(rst_n), .stby(stby), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
    .cap_in(cap_in), .clr_in(clr_in), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    logic [15:0] v, c0, c1;
    int total, threes;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); check("R1 count", v, 16'h0);
    rd(2'd1, v); check("R1 capture", v, 16'h0);
    rd(2'd2, v); check("R1 control", v, 16'h0);
    rd(2'd3, v); check("R1 status", v, 16'h0);
    check("R1 irq", {15'b0, irq}, 16'h0);

    // R4 two-state write, R13 control readback
    wr(2'd2, 16'h0003);
    repeat (6) @(negedge clk);
    rd(2'd2, v); check("R13 control sel", v, 16'h0003);
    rd(2'd0, c0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h1234;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(2'd0, v); check("R4 not yet after first state", v, c0);
    @(negedge clk);
    rd(2'd0, v); check("R4 written after second state", v, 16'h1234);

    // R6 clear in second state wins; clear in first state does not
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0777;
    @(negedge clk);
    bus_wr = 1'b0; clr_in = 1'b1;
    @(negedge clk);
    clr_in = 1'b0;
    rd(2'd0, v); check("R6 clear beats write", v, 16'h0000);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0777; clr_in = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; clr_in = 1'b0;
    @(negedge clk);
    rd(2'd0, v); check("R6 first-state clear keeps write", v, 16'h0777);

    // R5 clear beats counting
    wr(2'd2, 16'h0000);
    repeat (4) @(negedge clk);
    clr_in = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rd(2'd0, v); check("R5 held clear", v, 16'h0000);
    end
    clr_in = 1'b0;

    // R7 write beats increment, both prescaler parities
    for (int ph = 0; ph < 2; ph++) begin
      repeat (ph + 3) @(negedge clk);
      wr(2'd0, 16'h0100);
      @(negedge clk);
      rd(2'd0, v); check("R7 write exact", v, 16'h0100);
    end

    // R2 divider sweep
    for (int s = 0; s < 3; s++) begin
      wr(2'd2, 16'(s));
      repeat (16) @(negedge clk);
      for (int k = 1; k <= 3; k++) begin
        rd(2'd0, c0);
        repeat (8 * k) @(negedge clk);
        rd(2'd0, c1);
        check("R2 divided rate", c1 - c0, 16'((8 * k) >> (s + 1)));
      end
    end

    // R3 external pulse sweep
    wr(2'd2, 16'h0003);
    repeat (6) @(negedge clk);
    for (int h = 2; h <= 5; h++) begin
      for (int l = 2; l <= 5; l++) begin
        rd(2'd0, c0);
        for (int p = 0; p < 3; p++) begin
          @(negedge clk); ext_clk = 1'b1;
          repeat (h - 1) @(negedge clk);
          @(negedge clk); ext_clk = 1'b0;
          repeat (l - 1) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        rd(2'd0, c1);
        check("R3 external pulses", c1 - c0, 16'd3);
      end
    end

    // R8 switch from idle pin to divide-by-8, all eight phases
    total = 0; threes = 0;
    for (int it = 0; it < 8; it++) begin
      wr(2'd2, 16'h0003);
      repeat (4) @(negedge clk);
      rd(2'd0, c0);
      wr(2'd2, 16'h0002);
      repeat (17) @(negedge clk);
      rd(2'd0, c1);
      v = c1 - c0;
      check("R8 window count in range", {15'b0, (v == 16'd2 || v == 16'd3)}, 16'd1);
      total += int'(v);
      if (v == 16'd3) threes++;
    end
    check("R8 total events", 16'(total), 16'd19);
    check("R8 phases with switch count", 16'(threes), 16'd3);

    // R9 overflow and irq, R10 flag clearing
    wr(2'd2, 16'h0004);
    wr(2'd0, 16'hFFFF);
    @(negedge clk);
    rd(2'd0, v); check("R9 preload", v, 16'hFFFF);
    rd(2'd3, v); check("R9 no flag before wrap", v, 16'h0000);
    repeat (6) @(negedge clk);
    rd(2'd3, v); check("R9 overflow flag", v, 16'h0001);
    check("R9 irq", {15'b0, irq}, 16'h1);
    rd(2'd0, v); check("R9 wrapped low", {15'b0, v < 16'd4}, 16'h1);
    wr(2'd3, 16'hFFFF);
    @(negedge clk);
    rd(2'd3, v); check("R10 write one keeps flag", v, 16'h0001);
    wr(2'd2, 16'h0000);
    @(negedge clk);
    check("R9 irq masked", {15'b0, irq}, 16'h0);
    wr(2'd3, 16'h0000);
    @(negedge clk);
    rd(2'd3, v); check("R10 write zero clears", v, 16'h0000);

    // R11 capture
    wr(2'd2, 16'h0003);
    wr(2'd0, 16'h0ABC);
    repeat (4) @(negedge clk);
    cap_in = 1'b1;
    repeat (2) @(negedge clk);
    cap_in = 1'b0;
    repeat (4) @(negedge clk);
    rd(2'd1, v); check("R11 captured value", v, 16'h0ABC);
    rd(2'd3, v); check("R11 capture flag", v, 16'h0002);
    wr(2'd3, 16'h0001);
    @(negedge clk);
    rd(2'd3, v); check("R10 capture flag cleared", v, 16'h0000);

    // R12 standby
    wr(2'd2, 16'h0004);
    wr(2'd0, 16'hFFFE);
    repeat (8) @(negedge clk);
    check("R12 irq before standby", {15'b0, irq}, 16'h1);
    stby = 1'b1;
    @(negedge clk);
    rd(2'd0, c0);
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'h0055);
    clr_in = 1'b1;
    repeat (5) @(negedge clk);
    clr_in = 1'b0;
    rd(2'd0, v); check("R12 count frozen", v, c0);
    rd(2'd3, v); check("R12 flag kept", v, 16'h0001);
    check("R12 irq kept", {15'b0, irq}, 16'h1);
    stby = 1'b0;
    wr(2'd3, 16'h0000);
    @(negedge clk);
    check("R12 irq cleared after standby", {15'b0, irq}, 16'h0);

    report();
  end
endmodule